// File: doc/BRIEF.md
# Service-Level Split Router Input Port

This block is the receiving half of one port of a five-port packet router that moves 16-bit flits between neighbouring routers and local interfaces. Each clock cycle it looks at the flit on its input. It drops idle flits and flits whose service class is not supported. It writes every other flit into one of two small FIFOs, one per service class. The two classes never share storage, so the higher-priority signaling traffic can never be stuck behind read/write traffic.

Each FIFO has its own route tracker on its output side. The tracker takes the 4-bit destination field from the first flit of a packet and turns it into a one-hot request for one of five output directions. It keeps presenting that request for every later flit of the same packet, until the flit that closes the packet is popped. Output ports pop a FIFO with a read strobe. A per-class full signal goes back upstream as the flow-control credit.

Top module: `noc_in_port`

## Requirements
- R1: A flit carries its type in bits [15:14] and its service class in bits [13:12]. A non-idle flit of class 11 is stored in buffer 0 and one of class 10 in buffer 1. The oldest stored flit is shown on that buffer's `head_flit` slice, with `head_valid` high, in the cycle after the clock edge that wrote it.
- R2: A flit of type 00 (idle) is never stored, whatever its other bits hold.
- R3: A non-idle flit with class 00 or 01 is discarded. It sets `sl_err`, which stays high until reset.
- R4: Each buffer holds 4 flits in arrival order. Its `credit_full` bit is high exactly while it holds 4 flits, and it changes in the cycle after the edge that changed the occupancy.
- R5: A flit that arrives while its buffer is full is discarded, and the stored contents are left unchanged.
- R6: A high `rd` bit pops the head of that buffer at the clock edge. A read strobe on an empty buffer has no effect.
- R7: Type codes are 01 body, 10 end, 11 single-flit packet. A first flit is either a type 11 flit or a type 01 flit arriving when no packet is open on that class. For a first flit, bits [11:8] (0 north, 1 east, 2 south, 3 west, 4 local) select which bit of that buffer's 5-bit `head_dir` slice is set. Popping a type 01 first flit opens a packet. The following flits then present the same direction, whatever their bits [11:8] hold, until a type 10 or 11 flit is popped.
- R8: A first flit at the head whose route field holds 5 to 15 presents an all-zero `head_dir`. It sets `route_err` at the next edge, and the flag stays high until reset.
- R9: The two buffers are independent: reading or writing one never changes the head, direction or full state of the other.
- R10: After a synchronous active-low reset both buffers are empty, no packet is open, and `credit_full`, `sl_err` and `route_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_flit | input | 16 | Incoming flit; type 00 means no data |
| rd | input | 2 | Per-buffer pop strobe from the output ports |
| head_valid | output | 2 | Per-buffer head flit present |
| head_flit | output | 32 | Per-buffer head flit, buffer 0 in bits [15:0] |
| head_dir | output | 10 | Per-buffer one-hot direction request, buffer 0 in bits [4:0] |
| credit_full | output | 2 | Per-buffer full indication returned upstream |
| sl_err | output | 1 | Sticky unsupported-class flag |
| route_err | output | 1 | Sticky invalid-route flag |

## Verification
The bench builds the block with its default depth of four flits per buffer. At that depth every fill level, including the overflow drop and the read on an empty buffer, takes only a handful of cycles. This makes it practical to sweep every combination of type, class and route field through the block, with a pop after each flit. Packet-open state carries from one step of the sweep to the next, so the sweep also covers first-flit versus body-flit interpretation under many orderings. Directed runs add multi-flit packets whose body flits carry misleading route bits, and a fill of one class while the other drains.

// File: rtl/noc_in_pkg.sv
// Package: shared constants, flit field types and helper functions for the
// router input port. Assumes the flit layout fixed in the brief.
package noc_in_pkg;

    localparam int FLIT_W  = 16;
    localparam int NUM_SL  = 2;
    localparam int NUM_DIR = 5;
    localparam int ROUTE_W = 4;
    localparam int TYPE_HI = FLIT_W - 1;
    localparam int SL_HI   = FLIT_W - 3;
    localparam int ROUTE_HI = FLIT_W - 5;

    typedef enum logic [1:0] {
        FT_IDLE = 2'b00,
        FT_BODY = 2'b01,
        FT_END  = 2'b10,
        FT_FULL = 2'b11
    } flit_type_e;

    // Class code served by buffer index i: 0 -> 11, 1 -> 10.
    function automatic logic [1:0] class_code(input int idx);
        return 2'(3 - idx);
    endfunction

    // One-hot direction for a route field; zero when out of range.
    function automatic logic [NUM_DIR-1:0] route_decode(input logic [ROUTE_W-1:0] r);
        logic [NUM_DIR-1:0] v;
        v = '0;
        for (int d = 0; d < NUM_DIR; d++) begin
            if (r == ROUTE_W'(d)) v[d] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/flit_steer.sv
// Module: flit_steer
// Classifies the incoming flit and raises the write strobe of the buffer
// whose class code matches. Idle flits produce no write. Non-idle flits with
// an unsupported class set a sticky error flag.
// Assumes: one flit per cycle, type 00 marks an empty cycle.
module flit_steer
    import noc_in_pkg::*;
#(
    parameter int W   = FLIT_W,
    parameter int NSL = NUM_SL
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   flit,
    output logic [NSL-1:0] wr,
    output logic           sl_err
);
    localparam int T_HI = W - 1;
    localparam int S_HI = W - 3;

    flit_type_e ftype;
    logic [1:0] fclass;
    logic       known;

    // Decode header fields and build per-class write strobes.
    always_comb begin
        ftype  = flit_type_e'(flit[T_HI -: 2]);
        fclass = flit[S_HI -: 2];
        known  = 1'b0;
        wr     = '0;
        for (int i = 0; i < NSL; i++) begin
            if (fclass == class_code(i)) begin
                known = 1'b1;
                if (ftype != FT_IDLE) wr[i] = 1'b1;
            end
        end
    end

    // Sticky flag for non-idle flits of an unsupported class.
    always_ff @(posedge clk) begin
        if (!rst_n)                              sl_err <= 1'b0;
        else if (ftype != FT_IDLE && !known)     sl_err <= 1'b1;
    end

    assert_sl_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sl_err |=> sl_err);

    assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr));

endmodule

// File: rtl/sl_fifo.sv
// Module: sl_fifo
// Small circular FIFO for one service class. Writes into a full buffer and
// reads from an empty one are ignored. The head is shown combinationally
// from storage.
// Assumes: DEPTH >= 2.
module sl_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         rd,
    output logic [W-1:0] dout,
    output logic         valid,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    // Qualify requests against occupancy.
    always_comb begin
        do_wr = wr && (count != CAP);
        do_rd = rd && (count != '0);
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage array; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= din;
    end

    // Present head and status.
    always_comb begin
        dout  = mem[rptr];
        valid = (count != '0);
        full  = (count == CAP);
    end

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && !rd) |=> (full && $stable(dout)));

    assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && rd && !wr) |=> !valid);

    assert_fill_to_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CAP - 1'b1 && wr && !rd) |=> full);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP);

endmodule

// File: rtl/route_track.sv
// Module: route_track
// Watches the head of one class buffer. A first flit supplies the direction
// from its route field. Popping a body-type first flit opens a packet whose
// direction is held until a closing flit is popped.
// Assumes: head and pop strobe come from the same buffer.
module route_track
    import noc_in_pkg::*;
#(
    parameter int W    = FLIT_W,
    parameter int NDIR = NUM_DIR
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    head,
    input  logic            head_valid,
    input  logic            pop,
    output logic [NDIR-1:0] dir,
    output logic            bad_route
);
    localparam int T_HI = W - 1;
    localparam int R_HI = W - 5;

    flit_type_e      htype;
    logic            is_first;
    logic            open_q;
    logic [NDIR-1:0] route_q;
    logic [NDIR-1:0] fresh;

    // Classify the head flit and choose the presented direction.
    always_comb begin
        htype    = flit_type_e'(head[T_HI -: 2]);
        fresh    = route_decode(head[R_HI -: ROUTE_W]);
        is_first = (htype == FT_FULL) || (htype == FT_BODY && !open_q);
        if (!head_valid)    dir = '0;
        else if (is_first)  dir = fresh;
        else if (open_q)    dir = route_q;
        else                dir = '0;
        bad_route = head_valid && is_first && (fresh == '0);
    end

    // Packet-open state and held direction, updated on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= 1'b0;
            route_q <= '0;
        end else if (pop && head_valid) begin
            if (htype == FT_END || htype == FT_FULL) begin
                open_q <= 1'b0;
            end else if (htype == FT_BODY && !open_q) begin
                open_q  <= 1'b1;
                route_q <= fresh;
            end
        end
    end

    assert_dir_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dir));

    assert_route_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && head_valid && !pop) |=> $stable(dir));

    assert_held_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && !(pop && head_valid)) |=> $stable(route_q));

endmodule

// File: rtl/noc_in_port.sv
// Module: noc_in_port
// Input side of one router port. Steers flits by service class into
// independent buffers, tracks the route of each class's current packet, and
// returns per-class full credits upstream. Class 11 uses buffer 0, class 10
// buffer 1.
// Assumes: the sender honours credit_full; overflowing flits are dropped.
module noc_in_port
    import noc_in_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [FLIT_W-1:0]         in_flit,
    input  logic [NUM_SL-1:0]         rd,
    output logic [NUM_SL-1:0]         head_valid,
    output logic [NUM_SL*FLIT_W-1:0]  head_flit,
    output logic [NUM_SL*NUM_DIR-1:0] head_dir,
    output logic [NUM_SL-1:0]         credit_full,
    output logic                      sl_err,
    output logic                      route_err
);
    logic [NUM_SL-1:0] wr;
    logic [NUM_SL-1:0] bad;

    flit_steer #(.W(FLIT_W), .NSL(NUM_SL)) u_steer (
        .clk    (clk),
        .rst_n  (rst_n),
        .flit   (in_flit),
        .wr     (wr),
        .sl_err (sl_err)
    );

    for (genvar i = 0; i < NUM_SL; i++) begin : g_class
        sl_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr[i]),
            .din   (in_flit),
            .rd    (rd[i]),
            .dout  (head_flit[i*FLIT_W +: FLIT_W]),
            .valid (head_valid[i]),
            .full  (credit_full[i])
        );

        route_track #(.W(FLIT_W), .NDIR(NUM_DIR)) u_track (
            .clk        (clk),
            .rst_n      (rst_n),
            .head       (head_flit[i*FLIT_W +: FLIT_W]),
            .head_valid (head_valid[i]),
            .pop        (rd[i]),
            .dir        (head_dir[i*NUM_DIR +: NUM_DIR]),
            .bad_route  (bad[i])
        );
    end

    // Sticky flag for any first flit with an out-of-range route.
    always_ff @(posedge clk) begin
        if (!rst_n)    route_err <= 1'b0;
        else if (|bad) route_err <= 1'b1;
    end

    assert_route_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        route_err |=> route_err);

    assert_idle_no_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flit[FLIT_W-1 -: 2] == FT_IDLE && rd == '0)
            |=> ($stable(head_valid) && $stable(credit_full) && $stable(head_flit)));

    assert_credit_means_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((credit_full & ~head_valid) == '0));

endmodule

// File: tb/noc_in_port_test.sv
// Bench: sweeps header/route combinations and directed fill, drain and
// packet scenarios against an arithmetic model of the requirements.
module noc_in_port_test;
    localparam int W = 16;
    localparam int D = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in_flit = '0;
    logic [1:0]   rd = '0;
    logic [1:0]   head_valid;
    logic [31:0]  head_flit;
    logic [9:0]   head_dir;
    logic [1:0]   credit_full;
    logic         sl_err, route_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    logic [W-1:0] mq [2][D];
    int           mcnt [2];
    bit           mopen [2];
    logic [4:0]   mroute [2];
    bit           m_slerr, m_rterr;

    noc_in_port #(.DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .in_flit(in_flit), .rd(rd),
        .head_valid(head_valid), .head_flit(head_flit), .head_dir(head_dir),
        .credit_full(credit_full), .sl_err(sl_err), .route_err(route_err)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [4:0] dec(input logic [3:0] r);
        return (r < 5) ? 5'(1 << r) : 5'd0;
    endfunction

    function automatic bit is_first(input int i);
        logic [1:0] t;
        t = mq[i][0][15:14];
        return (t == 2'b11) || (t == 2'b01 && !mopen[i]);
    endfunction

    function automatic logic [4:0] exp_dir(input int i);
        if (mcnt[i] == 0) return 5'd0;
        if (is_first(i)) return dec(mq[i][0][11:8]);
        if (mopen[i]) return mroute[i];
        return 5'd0;
    endfunction

    task automatic compare(input string tag);
        for (int i = 0; i < 2; i++) begin
            chk(tag, "head_valid", int'(head_valid[i]), int'(mcnt[i] != 0));
            if (mcnt[i] != 0)
                chk(tag, "head_flit", int'(head_flit[i*W +: W]), int'(mq[i][0]));
            chk(tag, "head_dir", int'(head_dir[i*5 +: 5]), int'(exp_dir(i)));
            chk(tag, "credit_full", int'(credit_full[i]), int'(mcnt[i] == D));
        end
        chk(tag, "sl_err", int'(sl_err), int'(m_slerr));
        chk(tag, "route_err", int'(route_err), int'(m_rterr));
    endtask

    // One cycle: update the model, drive, clock, compare.
    task automatic step(input logic [W-1:0] f, input logic [1:0] r, input string tag);
        int  idx;
        bit  fullpre [2];
        logic [1:0] t;
        for (int i = 0; i < 2; i++) begin
            fullpre[i] = (mcnt[i] == D);
            if (mcnt[i] != 0 && is_first(i) && mq[i][0][11:8] > 4) m_rterr = 1;
        end
        for (int i = 0; i < 2; i++) begin
            if (r[i] && mcnt[i] != 0) begin
                t = mq[i][0][15:14];
                if (t == 2'b10 || t == 2'b11) mopen[i] = 0;
                else if (t == 2'b01 && !mopen[i]) begin
                    mopen[i] = 1;
                    mroute[i] = dec(mq[i][0][11:8]);
                end
                for (int k = 0; k < D - 1; k++) mq[i][k] = mq[i][k+1];
                mcnt[i]--;
            end
        end
        idx = -1;
        if (f[15:14] != 2'b00) begin
            if (f[13:12] == 2'b11) idx = 0;
            else if (f[13:12] == 2'b10) idx = 1;
            else m_slerr = 1;
        end
        if (idx >= 0 && !fullpre[idx]) begin
            mq[idx][mcnt[idx]] = f;
            mcnt[idx]++;
        end
        in_flit = f;
        rd = r;
        @(posedge clk);
        #1;
        in_flit = '0;
        rd = '0;
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            mcnt[i] = 0; mopen[i] = 0; mroute[i] = '0;
        end
        m_slerr = 0; m_rterr = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        compare("R10");

        // R1/R2/R3/R7/R8 sweep: every type, class and route field, each then popped.
        for (int t = 0; t < 4; t++) begin
            for (int s = 0; s < 4; s++) begin
                for (int r = 0; r < 16; r++) begin
                    logic [W-1:0] f;
                    string tg;
                    f = {2'(t), 2'(s), 4'(r), 8'((t * 37 + s * 11 + r * 5) & 8'hFF)};
                    if (t == 0) tg = "R2";
                    else if (s < 2) tg = "R3";
                    else if (r > 4) tg = "R8";
                    else if (t == 1) tg = "R7";
                    else tg = "R1";
                    step(f, 2'b00, tg);
                    step('0, 2'b11, "R6");
                end
            end
        end

        // R7: multi-flit packet on class 10, body carries misleading route bits.
        step({2'b01, 2'b10, 4'd2, 8'hA1}, 2'b00, "R7");
        step({2'b01, 2'b10, 4'd4, 8'hA2}, 2'b00, "R7");
        step({2'b01, 2'b10, 4'd15, 8'hA3}, 2'b00, "R7");
        step({2'b10, 2'b10, 4'd0, 8'hA4}, 2'b00, "R7");
        for (int k = 0; k < 4; k++) step('0, 2'b10, "R7");

        // R4/R5: fill class 11 beyond capacity.
        for (int k = 0; k < 5; k++)
            step({2'b11, 2'b11, 4'(k % 5), 8'(8'h10 + k)}, 2'b00, (k < 4) ? "R4" : "R5");
        // R9: fill class 10 while draining class 11.
        for (int k = 0; k < 4; k++)
            step({2'b11, 2'b10, 4'(3 - k), 8'(8'h40 + k)}, 2'b01, "R9");
        // R4: write and read together on a full buffer.
        step({2'b11, 2'b10, 4'd1, 8'h55}, 2'b10, "R4");
        // R6: drain and read on empty.
        for (int k = 0; k < 6; k++) step('0, 2'b11, "R6");
        step({2'b00, 2'b11, 4'd1, 8'h77}, 2'b11, "R2");

        // R10: reset again clears everything.
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < 2; i++) begin
            mcnt[i] = 0; mopen[i] = 0; mroute[i] = '0;
        end
        m_slerr = 0; m_rterr = 0;
        compare("R10");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule